// File: doc/BRIEF.md
# Extended-State Save Fault Checker

This block decides, before any memory is written, whether a privileged extended-state save may proceed. It takes one request at a time: the operating mode, the privilege level, the linear and effective addresses of the save area, the result of the segment limit check, the control and feature bits that gate the operation, and the lock-prefix flag. It returns one fault class, together with a flag that tells whether an error code (always zero) goes with it.

The decision is ranked. An invalid-opcode cause wins over everything else. Device-not-available comes next, then general protection, then stack fault. Alongside the decision, the block also forms the 64-bit component mask from the low 32 bits of the two mask source registers and drops their upper halves. Results are registered, so they appear one clock after the request. Page-fault detection and the save itself are handled elsewhere.

Top module: `xs_fault_chk`

## Requirements
- R1: `valid_o` and `fault_o` answer a `req_i` sampled at one rising edge after that edge. Fault codes are 0 none, 1 invalid opcode, 2 device not available, 3 general protection, 4 stack fault. Mode codes are 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit. When no request was sampled, and during reset, `valid_o`=0 and `fault_o`=0.
- R2: Invalid opcode (1) is reported when any of these holds: `lock_i`=1, `feat_save_i`=0, `feat_sup_i`=0, or `os_en_i`=0. It overrides every other cause.
- R3: With no invalid-opcode cause present, `ts_i`=1 gives device not available (2). It overrides every address and privilege cause.
- R4: In every mode except real, `cpl_i`≠0 gives general protection. In real mode the privilege level is ignored.
- R5: Bits [5:0] of `lin_addr_i` not all zero (a save area that is not on a 64-byte boundary) gives general protection in every mode.
- R6: In 64-bit mode, `lin_addr_i` is non-canonical when bits [63:47] are not all equal. A non-canonical address gives stack fault if `stk_seg_i`=1 and general protection otherwise.
- R7: In real mode, `eff_addr_i` + `len_i` > 0x10000 (some byte of the save area lies above 0xFFFF) gives general protection. A sum of exactly 0x10000 is accepted.
- R8: In protected, virtual-8086 and compatibility modes, `lim_fail_i`=1 gives stack fault if `stk_seg_i`=1 and general protection otherwise. `lim_fail_i` is ignored in real and 64-bit modes.
- R9: When a general-protection cause and a stack-fault cause are present together, general protection is reported.
- R10: `has_errc_o`=1 exactly when the result is general protection or stack fault and the mode is not real. The error code that goes with it is zero.
- R11: On each request, `mask_o` is loaded with {`rdx_i`[31:0], `rax_i`[31:0]}. The upper 32 bits of both inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Evaluate the presented operands this cycle |
| mode_i | input | 3 | Operating mode code |
| cpl_i | input | 2 | Current privilege level |
| lin_addr_i | input | 64 | Linear address of the save area |
| eff_addr_i | input | 32 | Effective address (real-mode range check) |
| len_i | input | 16 | Save-area length in bytes |
| lim_fail_i | input | 1 | Segment limit check failed |
| stk_seg_i | input | 1 | Operand is referenced through the stack segment |
| ts_i | input | 1 | Task-switched control bit |
| os_en_i | input | 1 | OS extended-state enable bit |
| feat_save_i | input | 1 | Base save feature supported |
| feat_sup_i | input | 1 | Supervisor-state save supported |
| lock_i | input | 1 | Lock prefix present |
| rax_i | input | 64 | Low mask source register |
| rdx_i | input | 64 | High mask source register |
| valid_o | output | 1 | Result valid |
| fault_o | output | 3 | Fault code |
| has_errc_o | output | 1 | A zero error code accompanies the fault |
| mask_o | output | 64 | Component mask formed from the low register halves |

## Verification
The bound checker watches the following on every cycle: the one-cycle request-to-result latency, the idle state, the invalid-opcode and device-not-available overrides, the privilege and alignment causes, the rule that no error code goes with those classes, and the loading of the mask. Three things are shown only by the bench's scenarios. The first is how mode selects among canonical, segment-limit and real-mode range checks. The second is the exact boundary at 0x10000. The third is the ranking when general-protection and stack-fault causes collide.

// File: rtl/xs_fault_pkg.sv
package xs_fault_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_NM   = 3'd2,
    FLT_GP   = 3'd3,
    FLT_SS   = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    MD_REAL   = 3'd0,
    MD_PROT   = 3'd1,
    MD_V86    = 3'd2,
    MD_COMPAT = 3'd3,
    MD_LONG   = 3'd4
  } mode_e;

  typedef struct packed {
    logic ud;
    logic nm;
  } gate_flt_t;

  typedef struct packed {
    logic gp;
    logic ss;
  } addr_flt_t;
endpackage

// File: rtl/xs_gate_chk.sv
module xs_gate_chk
  import xs_fault_pkg::*;
(
  input  logic      lock_i,
  input  logic      feat_save_i,
  input  logic      feat_sup_i,
  input  logic      os_en_i,
  input  logic      ts_i,
  output gate_flt_t gate_o
);
  always_comb begin
    gate_o.ud = lock_i | ~feat_save_i | ~feat_sup_i | ~os_en_i;
    gate_o.nm = ts_i;
  end
endmodule

// File: rtl/xs_addr_chk.sv
module xs_addr_chk
  import xs_fault_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int VA_BITS     = 48,
  parameter int EFF_W       = 32,
  parameter int LEN_W       = 16,
  parameter int ALIGN_BITS  = 6,
  parameter int REAL_SPAN_W = 16
) (
  input  logic [2:0]        mode_i,
  input  logic [1:0]        cpl_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic [EFF_W-1:0]  eff_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              lim_fail_i,
  input  logic              stk_seg_i,
  output addr_flt_t         addr_o
);
  localparam int SUM_W = EFF_W + 1;
  localparam logic [SUM_W-1:0] REAL_END = SUM_W'(1) << REAL_SPAN_W;

  logic is_real, is_long, is_seg;
  logic canon, misalign, priv_bad, real_over;
  logic [SUM_W-1:0] end_sum;

  assign is_real = (mode_i == MD_REAL);
  assign is_long = (mode_i == MD_LONG);
  assign is_seg  = ~is_real & ~is_long;

  generate
    if (VA_BITS < ADDR_W) begin : g_canon
      localparam int HI_W = ADDR_W - VA_BITS + 1;
      logic [HI_W-1:0] hi_bits;
      logic unused_mid;
      assign hi_bits    = lin_addr_i[ADDR_W-1:VA_BITS-1];
      assign canon      = (&hi_bits) | ~(|hi_bits);
      assign unused_mid = ^lin_addr_i[VA_BITS-2:ALIGN_BITS];
    end else begin : g_flat
      logic unused_mid;
      assign canon      = 1'b1;
      assign unused_mid = ^lin_addr_i[ADDR_W-1:ALIGN_BITS];
    end
  endgenerate

  assign misalign  = |lin_addr_i[ALIGN_BITS-1:0];
  assign priv_bad  = ~is_real & (cpl_i != 2'd0);
  assign end_sum   = {1'b0, eff_addr_i} + SUM_W'(len_i);
  assign real_over = is_real & (end_sum > REAL_END);

  always_comb begin
    addr_o.gp = misalign | priv_bad | real_over
              | (is_long & ~canon & ~stk_seg_i)
              | (is_seg & lim_fail_i & ~stk_seg_i);
    addr_o.ss = (is_long & ~canon & stk_seg_i)
              | (is_seg & lim_fail_i & stk_seg_i);
  end
endmodule

// File: rtl/xs_fault_prio.sv
module xs_fault_prio
  import xs_fault_pkg::*;
(
  input  gate_flt_t  gate_i,
  input  addr_flt_t  addr_i,
  input  logic [2:0] mode_i,
  output logic [2:0] fault_o,
  output logic       has_errc_o
);
  fault_e sel;

  always_comb begin
    if (gate_i.ud)      sel = FLT_UD;
    else if (gate_i.nm) sel = FLT_NM;
    else if (addr_i.gp) sel = FLT_GP;
    else if (addr_i.ss) sel = FLT_SS;
    else                sel = FLT_NONE;
  end

  assign fault_o    = sel;
  assign has_errc_o = ((sel == FLT_GP) | (sel == FLT_SS)) & (mode_i != MD_REAL);
endmodule

// File: rtl/xs_fault_chk.sv
module xs_fault_chk
  import xs_fault_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int VA_BITS     = 48,
  parameter int EFF_W       = 32,
  parameter int LEN_W       = 16,
  parameter int ALIGN_BITS  = 6,
  parameter int REAL_SPAN_W = 16,
  parameter int MASK_W      = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        cpl_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic [EFF_W-1:0]  eff_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              lim_fail_i,
  input  logic              stk_seg_i,
  input  logic              ts_i,
  input  logic              os_en_i,
  input  logic              feat_save_i,
  input  logic              feat_sup_i,
  input  logic              lock_i,
  input  logic [MASK_W-1:0] rax_i,
  input  logic [MASK_W-1:0] rdx_i,
  output logic              valid_o,
  output logic [2:0]        fault_o,
  output logic              has_errc_o,
  output logic [MASK_W-1:0] mask_o
);
  localparam int HALF = MASK_W / 2;

  gate_flt_t gate;
  addr_flt_t addr;
  logic [2:0] fault_d;
  logic errc_d;
  logic [MASK_W-1:0] mask_d;
  logic unused_hi;

  xs_gate_chk u_gate (
    .lock_i      (lock_i),
    .feat_save_i (feat_save_i),
    .feat_sup_i  (feat_sup_i),
    .os_en_i     (os_en_i),
    .ts_i        (ts_i),
    .gate_o      (gate)
  );

  xs_addr_chk #(
    .ADDR_W      (ADDR_W),
    .VA_BITS     (VA_BITS),
    .EFF_W       (EFF_W),
    .LEN_W       (LEN_W),
    .ALIGN_BITS  (ALIGN_BITS),
    .REAL_SPAN_W (REAL_SPAN_W)
  ) u_addr (
    .mode_i     (mode_i),
    .cpl_i      (cpl_i),
    .lin_addr_i (lin_addr_i),
    .eff_addr_i (eff_addr_i),
    .len_i      (len_i),
    .lim_fail_i (lim_fail_i),
    .stk_seg_i  (stk_seg_i),
    .addr_o     (addr)
  );

  xs_fault_prio u_prio (
    .gate_i     (gate),
    .addr_i     (addr),
    .mode_i     (mode_i),
    .fault_o    (fault_d),
    .has_errc_o (errc_d)
  );

  // upper register halves are architecturally ignored
  assign mask_d    = {rdx_i[HALF-1:0], rax_i[HALF-1:0]};
  assign unused_hi = ^{rdx_i[MASK_W-1:HALF], rax_i[MASK_W-1:HALF]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      fault_o    <= FLT_NONE;
      has_errc_o <= 1'b0;
      mask_o     <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        fault_o    <= fault_d;
        has_errc_o <= errc_d;
        mask_o     <= mask_d;
      end else begin
        fault_o    <= FLT_NONE;
        has_errc_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xs_fault_chk_sva.sv
module xs_fault_chk_sva #(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 6,
  parameter int MASK_W     = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [2:0]        mode_i,
  input logic [1:0]        cpl_i,
  input logic [ADDR_W-1:0] lin_addr_i,
  input logic              ts_i,
  input logic              os_en_i,
  input logic              feat_save_i,
  input logic              feat_sup_i,
  input logic              lock_i,
  input logic [MASK_W-1:0] rax_i,
  input logic [MASK_W-1:0] rdx_i,
  input logic              valid_o,
  input logic [2:0]        fault_o,
  input logic              has_errc_o,
  input logic [MASK_W-1:0] mask_o
);
  localparam int HALF = MASK_W / 2;

  logic ud_cause, gate_ok;
  assign ud_cause = lock_i | ~feat_save_i | ~feat_sup_i | ~os_en_i;
  assign gate_ok  = ~ud_cause & ~ts_i;

  AST_REQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R1
  AST_IDLE_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (fault_o == 3'd0 && !has_errc_o)); // R1
  AST_UD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ud_cause) |=> fault_o == 3'd1); // R2
  AST_NM_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ud_cause && ts_i) |=> fault_o == 3'd2); // R3
  AST_CPL_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && gate_ok && mode_i != 3'd0 && cpl_i != 2'd0) |=> fault_o == 3'd3); // R4
  AST_ALIGN_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && gate_ok && lin_addr_i[ALIGN_BITS-1:0] != '0) |=> fault_o == 3'd3); // R5
  AST_NO_ERRC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o inside {3'd0, 3'd1, 3'd2}) |-> !has_errc_o); // R10
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> mask_o == {$past(rdx_i[HALF-1:0]), $past(rax_i[HALF-1:0])}); // R11
endmodule

bind xs_fault_chk xs_fault_chk_sva #(
  .ADDR_W     (ADDR_W),
  .ALIGN_BITS (ALIGN_BITS),
  .MASK_W     (MASK_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .mode_i      (mode_i),
  .cpl_i       (cpl_i),
  .lin_addr_i  (lin_addr_i),
  .ts_i        (ts_i),
  .os_en_i     (os_en_i),
  .feat_save_i (feat_save_i),
  .feat_sup_i  (feat_sup_i),
  .lock_i      (lock_i),
  .rax_i       (rax_i),
  .rdx_i       (rdx_i),
  .valid_o     (valid_o),
  .fault_o     (fault_o),
  .has_errc_o  (has_errc_o),
  .mask_o      (mask_o)
);

// File: tb/xs_fault_chk_bench.sv
module xs_fault_chk_bench;
  typedef struct packed {
    logic [2:0]  md;
    logic [1:0]  cpl;
    logic [63:0] lin;
    logic [31:0] eff;
    logic [15:0] len;
    logic        lim;
    logic        stk;
    logic        ts;
    logic        os;
    logic        fs;
    logic        fsup;
    logic        lock;
    logic [2:0]  exp;
    logic        errc;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 24;
  // md cpl lin eff len lim stk ts os fs fsup lock exp errc req
  localparam vec_t VECS [NV] = '{
    '{3'd1, 2'd0, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'd1},  // R1 clean
    '{3'd1, 2'd0, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 8'd2},  // R2 lock
    '{3'd1, 2'd0, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 8'd2},  // R2 over ts
    '{3'd4, 2'd3, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 8'd2},  // R2 os off
    '{3'd1, 2'd0, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 8'd2},  // R2 sup off
    '{3'd1, 2'd3, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 8'd3},  // R3 over cpl
    '{3'd1, 2'd3, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'd4},  // R4 prot
    '{3'd0, 2'd3, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'd4},  // R4 real ignores
    '{3'd2, 2'd3, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'd4},  // R4 v86
    '{3'd3, 2'd1, 64'h1000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'd4},  // R4 compat
    '{3'd4, 2'd0, 64'h1020, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'd5},  // R5 long
    '{3'd0, 2'd0, 64'h1001, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 8'd5},  // R5 R10 real
    '{3'd4, 2'd0, 64'h0000_8000_0000_0000, 32'h1000, 16'h240, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'd6},  // R6 gp
    '{3'd4, 2'd0, 64'h0000_8000_0000_0000, 32'h1000, 16'h240, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 1'b1, 8'd6},  // R6 ss
    '{3'd4, 2'd0, 64'hFFFF_8000_0000_0000, 32'h1000, 16'h240, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'd6},  // R6 canon
    '{3'd0, 2'd0, 64'h1000, 32'hFE00, 16'h200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'd7},  // R7 edge ok
    '{3'd0, 2'd0, 64'h1000, 32'hFE40, 16'h200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 8'd7},  // R7 over
    '{3'd1, 2'd0, 64'h1000, 32'h1000, 16'h240, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'd8},  // R8 data
    '{3'd3, 2'd0, 64'h1000, 32'h1000, 16'h240, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 1'b1, 8'd8},  // R8 stack
    '{3'd4, 2'd0, 64'h1000, 32'h1000, 16'h240, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'd8},  // R8 long ign
    '{3'd0, 2'd0, 64'h1000, 32'h1000, 16'h240, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'd8},  // R8 real ign
    '{3'd2, 2'd3, 64'h1000, 32'h1000, 16'h240, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'd9},  // R9 cpl vs ss
    '{3'd4, 2'd0, 64'h0000_8000_0000_0008, 32'h1000, 16'h240, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'd9},  // R9 align vs ss
    '{3'd0, 2'd0, 64'h1000, 32'h0001_0000, 16'h1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 8'd3}   // R3 over real range
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] mode = '0;
  logic [1:0] cpl = '0;
  logic [63:0] lin = '0;
  logic [31:0] eff = '0;
  logic [15:0] len = '0;
  logic lim = 1'b0, stk = 1'b0, ts = 1'b0, os = 1'b1, fs = 1'b1, fsup = 1'b1, lck = 1'b0;
  logic [63:0] rax = '0, rdx = '0;
  logic valid, errc;
  logic [2:0] fault;
  logic [63:0] mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xs_fault_chk u_xs_fault_chk (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode), .cpl_i(cpl),
    .lin_addr_i(lin), .eff_addr_i(eff), .len_i(len), .lim_fail_i(lim),
    .stk_seg_i(stk), .ts_i(ts), .os_en_i(os), .feat_save_i(fs),
    .feat_sup_i(fsup), .lock_i(lck), .rax_i(rax), .rdx_i(rdx),
    .valid_o(valid), .fault_o(fault), .has_errc_o(errc), .mask_o(mask)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    mode = v.md; cpl = v.cpl; lin = v.lin; eff = v.eff; len = v.len;
    lim = v.lim; stk = v.stk; ts = v.ts; os = v.os; fs = v.fs;
    fsup = v.fsup; lck = v.lock; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check($sformatf("R%0d valid", v.rq), {63'd0, valid}, 64'd1);
    check($sformatf("R%0d fault", v.rq), {61'd0, fault}, {61'd0, v.exp});
    check($sformatf("R%0d errc (R10)", v.rq), {63'd0, errc}, {63'd0, v.errc});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", {63'd0, valid}, 64'd0);
    check("R1 reset fault", {61'd0, fault}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1 idle after request
    @(negedge clk);
    check("R1 idle valid", {63'd0, valid}, 64'd0);
    check("R1 idle fault", {61'd0, fault}, 64'd0);

    // R11 upper halves ignored
    rax = 64'hDEAD_BEEF_1234_5678; rdx = 64'hCAFE_0000_0BAD_F00D;
    run_vec(VECS[0]);
    check("R11 mask", mask, 64'h0BAD_F00D_1234_5678);
    rax = 64'h0000_0000_1234_5678; rdx = 64'hFFFF_FFFF_0BAD_F00D;
    run_vec(VECS[0]);
    check("R11 mask upper ignored", mask, 64'h0BAD_F00D_1234_5678);
    rax = 64'hFFFF_FFFF_0000_0001; rdx = 64'h1111_1111_8000_0000;
    run_vec(VECS[0]);
    check("R11 mask new", mask, 64'h8000_0000_0000_0001);

    // R1 reset mid-run clears result
    @(negedge clk);
    req = 1'b1; lck = 1'b1;
    @(negedge clk);
    req = 1'b0; rst_n = 1'b0;
    #1;
    check("R1 async reset fault", {61'd0, fault}, 64'd0);
    check("R1 async reset mask", mask, 64'd0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule